// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is a write-only I2C target that fills a bank of eight-bit configuration registers from a bus master. It oversamples SCL and SDA with a faster system clock and detects START and STOP conditions. It then checks the device address, which is a fixed six-bit prefix plus one bit taken from a strap input. Only write requests are acknowledged. Read requests are left unanswered.

After an accepted address, the next byte selects a register through a six-bit pointer. Every byte that follows is stored at the pointer, and the pointer then moves to the next register. When the pointer steps past the last implemented register it returns to zero, so a long burst overwrites the start of the bank. Pointer values above the last register are acknowledged, but the data sent to them is dropped. All register contents are available at once on a flat parallel output.

The block never drives SDA high. It only enables an open-drain pull-down during acknowledge bits.

Top module: `i2c_cfg_target`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START at any point, including part-way through a byte, discards the byte in progress and restarts address matching.
- R2: The first byte after START is 7 address bits then a direction bit, MSB first. Address bits 7..2 must equal 001001, bit 1 must equal `addr_strap_i`, and the direction bit 0 means write. On a match with direction 0, the block acknowledges by holding SDA low through the ninth SCL pulse.
- R3: On an address mismatch or a read request (direction bit 1), SDA is never pulled low. No later byte is acknowledged or stored until the next START.
- R4: The sub-address byte and every data byte are acknowledged on the ninth pulse. The pull-down is released after the SCL falling edge that ends the acknowledge pulse.
- R5: The low six bits of the second byte load the register pointer.
- R6: Each byte after the sub-address is stored, MSB first, in the register at the pointer, and the pointer then increments by one.
- R7: When a byte is written to register 27h, the pointer wraps to 00h, so the following data overwrites 00h upward.
- R8: A pointer in 28h..3Fh still produces acknowledges, but the data is discarded. The pointer keeps counting and goes from 3Fh to 00h, after which writes take effect again.
- R9: Synchronous active-low reset clears every register to 00h and releases SDA.
- R10: Register n appears on `regs_o[8n+7:8n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap_i | input | 1 | Strap level that sets the last device address bit |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| regs_o | output | NUM_REGS*8 (320) | Flat register contents, register n at bits 8n+7:8n |

## Verification
The bench builds the block with its default parameters: 40 registers, a six-bit pointer, the 001001 prefix and two synchronizer stages. With these values the real wrap point 27h is in reach, and so is the unimplemented pointer range 28h..3Fh together with its 3Fh-to-00h rollover. The bench runs SCL at one fortieth of the system clock. This leaves several synchronizer delays inside each SCL phase, so acknowledge timing is tested with margin. Both strap levels are tried, so the bench checks that the strap bit really takes part in the address match.

// File: rtl/i2c_cfg_pkg.sv
// Shared types for the I2C configuration target.
package i2c_cfg_pkg;

    // Link-level state of the byte engine.
    typedef enum logic [1:0] {
        ST_IDLE,   // waiting for START
        ST_RX,     // shifting in a byte
        ST_ACK,    // holding SDA low for the ninth pulse
        ST_SKIP    // not addressed, wait for next START
    } link_state_t;

    // Which byte of the transaction is being received.
    typedef enum logic [1:0] {
        PH_DEV,    // device address + direction
        PH_SUB,    // register sub-address
        PH_DATA    // register data
    } byte_phase_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL and SDA into the system clock domain and derives
// SCL edges and START/STOP events.
// Assumes: clk is at least 8x SCL, so each SCL phase spans several clocks.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    generate
        if (STAGES == 1) begin : g_single
            // One-stage capture of both lines.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= 1'b1;
                    sda_pipe <= 1'b1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_chain
            // Multi-stage shift chain; idle bus reads as high.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Previous synchronized values, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_q;
    assign scl_fall  = ~scl_s &  scl_q;
    assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
    assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

    // START and STOP can never be flagged in the same cycle.
    AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det)); // R1

endmodule

// File: rtl/i2c_byte_engine.sv
// Receives bytes from the synchronized bus, matches the device address,
// drives the acknowledge and hands the sub-address and data bytes on.
// Assumes: edge and condition strobes come from i2c_line_sync.
module i2c_byte_engine
    import i2c_cfg_pkg::*;
#(
    parameter logic [5:0] ADDR_PREFIX = 6'b001001,
    parameter int         PTR_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             addr_strap,
    output logic             sda_oe,
    output logic             sub_load,
    output logic [PTR_W-1:0] sub_val,
    output logic             wr_en,
    output logic [7:0]       wr_data
);

    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    link_state_t state;
    byte_phase_t phase;
    logic [3:0]  bit_cnt;
    logic [7:0]  shreg;
    logic        addr_hit;

    assign addr_hit = (shreg[7:1] == {ADDR_PREFIX, addr_strap}) && !shreg[0];
    assign sub_val  = shreg[PTR_W-1:0];
    assign wr_data  = shreg;

    // Bus protocol state machine: shift, acknowledge, skip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            phase    <= PH_DEV;
            bit_cnt  <= '0;
            shreg    <= '0;
            sda_oe   <= 1'b0;
            sub_load <= 1'b0;
            wr_en    <= 1'b0;
        end else begin
            sub_load <= 1'b0;
            wr_en    <= 1'b0;
            if (start_det) begin
                state   <= ST_RX;
                phase   <= PH_DEV;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && bit_cnt != BITS_PER_BYTE) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == BITS_PER_BYTE) begin
                            case (phase)
                                PH_DEV: begin
                                    if (addr_hit) begin
                                        sda_oe <= 1'b1;
                                        state  <= ST_ACK;
                                    end else begin
                                        state  <= ST_SKIP;
                                    end
                                end
                                PH_SUB: begin
                                    sda_oe   <= 1'b1;
                                    state    <= ST_ACK;
                                    sub_load <= 1'b1;
                                end
                                default: begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                    wr_en  <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            state   <= ST_RX;
                            bit_cnt <= '0;
                            phase   <= (phase == PH_DEV) ? PH_SUB : PH_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // A START always rearms the receiver with SDA released.
    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RX && phase == PH_DEV && bit_cnt == 4'd0 && !sda_oe)); // R1

    // A read request is never acknowledged.
    AST_READ_NOT_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RX && phase == PH_DEV && scl_fall && bit_cnt == BITS_PER_BYTE
         && shreg[0] && !start_det && !stop_det) |=> !sda_oe); // R3

    // An unaddressed engine never pulls SDA.
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_oe); // R3

    // The pull-down starts only while SCL is low.
    AST_OE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s); // R4

    // The pull-down ends right after the falling edge that closes the ack pulse.
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && scl_fall) |=> !sda_oe); // R4

endmodule

// File: rtl/i2c_reg_bank.sv
// Holds the configuration registers and the auto-incrementing pointer.
// Assumes: sub_load and wr_en are single-cycle strobes, never together.
module i2c_reg_bank #(
    parameter int NUM_REGS = 40,
    parameter int PTR_W    = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sub_load,
    input  logic [PTR_W-1:0]      sub_val,
    input  logic                  wr_en,
    input  logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);

    logic [PTR_W-1:0] ptr;
    logic             ptr_valid;

    assign ptr_valid = (int'(ptr) < NUM_REGS);

    // Pointer: loaded by the sub-address, stepped by each data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (sub_load) begin
            ptr <= sub_val;
        end else if (wr_en) begin
            ptr <= (ptr == LAST_IDX) ? '0 : ptr + 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            // Register i stores the data byte when the pointer selects it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs_flat[8*i +: 8] <= 8'h00;
                end else if (wr_en && ptr == PTR_W'(i)) begin
                    regs_flat[8*i +: 8] <= wr_data;
                end
            end
        end
    endgenerate

    // A write below the last register steps the pointer by one.
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr != LAST_IDX) |=> (ptr == $past(ptr) + 1'b1)); // R6

    // A write to the last register wraps the pointer to zero.
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == LAST_IDX) |=> (ptr == '0)); // R7

    // A write beyond the bank changes no register.
    AST_DISCARD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ptr_valid) |=> $stable(regs_flat)); // R8

endmodule

// File: rtl/i2c_cfg_target.sv
// Top of the write-only I2C configuration target: synchronizer, byte
// engine and register bank. SDA is only ever pulled low via sda_oe_o.
// Assumes: clk runs at least 8x the SCL rate; no clock stretching.
module i2c_cfg_target #(
    parameter int         NUM_REGS    = 40,
    parameter int         PTR_W       = 6,
    parameter logic [5:0] ADDR_PREFIX = 6'b001001,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic                  addr_strap_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] regs_o
);

    logic             scl_s;
    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             sub_load;
    logic [PTR_W-1:0] sub_val;
    logic             wr_en;
    logic [7:0]       wr_data;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_byte_engine #(
        .ADDR_PREFIX (ADDR_PREFIX),
        .PTR_W       (PTR_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .addr_strap (addr_strap_i),
        .sda_oe     (sda_oe_o),
        .sub_load   (sub_load),
        .sub_val    (sub_val),
        .wr_en      (wr_en),
        .wr_data    (wr_data)
    );

    i2c_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .PTR_W    (PTR_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_load  (sub_load),
        .sub_val   (sub_val),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .regs_flat (regs_o)
    );

    // Reset leaves SDA released.
    AST_RESET_RELEASED: assert property (@(posedge clk)
        $past(!rst_n) |-> !sda_oe_o); // R9

endmodule

// File: tb/i2c_cfg_target_tb.sv
// Self-checking bench for i2c_cfg_target: a vector table of single-byte
// write transactions, then directed bursts, wraps, restarts and reset.
module i2c_cfg_target_tb;

    localparam int NREG = 40;
    localparam int Q    = 10;   // system clocks per SCL quarter period
    localparam int NVEC = 7;

    // Vector table: strap, first byte, sub-address, data, expected ack.
    localparam logic       T_STRAP [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic [7:0] T_DEV   [NVEC] = '{8'h24, 8'h26, 8'h25, 8'h24, 8'h44, 8'h26, 8'h24};
    localparam logic [7:0] T_SUB   [NVEC] = '{8'h00, 8'h05, 8'h06, 8'h27, 8'h07, 8'h08, 8'h09};
    localparam logic [7:0] T_DATA  [NVEC] = '{8'hA5, 8'h11, 8'h22, 8'h3C, 8'h33, 8'hC3, 8'h99};
    localparam logic       T_ACK   [NVEC] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scl_m = 1'b1;
    logic              sda_m = 1'b1;
    logic              strap = 1'b0;
    logic              sda_oe;
    logic [NREG*8-1:0] regs;
    logic              sda_line;
    logic [7:0]        model [NREG];
    int                n_chk = 0;
    int                n_bad = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;   // 250 MHz

    i2c_cfg_target u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .addr_strap_i (strap),
        .sda_oe_o     (sda_oe),
        .regs_o       (regs)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        int idx = -1;
        for (int i = NREG - 1; i >= 0; i--)
            if (regs[8*i +: 8] !== model[i]) idx = i;
        if (idx < 0) check(req, 32'd0, 32'd0);
        else check($sformatf("%s reg%0h", req, idx), 32'(regs[8*idx +: 8]), 32'(model[idx]));
    endtask

    task automatic wait_q();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q(); wait_q();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        ack = ~sda_line;
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    // Watchdog: a hung run is a failed check and still summarizes.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic a;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        wait_q();

        // R9: reset state
        check("R9 oe after reset", 32'(sda_oe), 32'd0);
        check_regs("R9 regs after reset");

        // Table walk: one-byte writes with matching and non-matching addresses.
        for (int v = 0; v < NVEC; v++) begin
            strap = T_STRAP[v];
            bus_start();
            send_byte(T_DEV[v], a);
            check($sformatf("R2/R3 dev ack vec%0d", v), 32'(a), 32'(T_ACK[v]));
            send_byte(T_SUB[v], a);
            check($sformatf("R4/R3 sub ack vec%0d", v), 32'(a), 32'(T_ACK[v]));
            send_byte(T_DATA[v], a);
            check($sformatf("R4/R3 data ack vec%0d", v), 32'(a), 32'(T_ACK[v]));
            check("R4 released after ack", 32'(sda_oe), 32'd0);
            bus_stop();
            if (T_ACK[v]) model[T_SUB[v][5:0]] = T_DATA[v];
            check_regs($sformatf("R5/R6 store vec%0d", v));
        end
        check("R10 top slot holds reg27", 32'(regs[8*39 +: 8]), 32'h3C);

        // R7: burst across 27h wraps and overwrites 00h.
        strap = 1'b0;
        bus_start();
        send_byte(8'h24, a);
        send_byte(8'h26, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        check("R7 ack after wrap", 32'(a), 32'd1);
        bus_stop();
        model[8'h26] = 8'h11; model[8'h27] = 8'h22; model[0] = 8'h33;
        check_regs("R7 wrap burst");

        // R8: pointer above bank: acked, discarded, resumes at 00h after 3Fh.
        bus_start();
        send_byte(8'h24, a);
        send_byte(8'h3E, a);
        check("R8 high sub ack", 32'(a), 32'd1);
        send_byte(8'h44, a);
        check("R8 high data ack", 32'(a), 32'd1);
        send_byte(8'h55, a);
        send_byte(8'h66, a);
        bus_stop();
        model[0] = 8'h66;
        check_regs("R8 discard then 00h");

        // R1: START part-way through a data byte restarts matching.
        bus_start();
        send_byte(8'h24, a);
        send_byte(8'h03, a);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        send_byte(8'h24, a);
        check("R1 restart dev ack", 32'(a), 32'd1);
        send_byte(8'h04, a);
        send_byte(8'h5A, a);
        bus_stop();
        model[4] = 8'h5A;
        check_regs("R1 restart keeps reg03");

        // R3: after a refused address, a START re-enables acknowledges.
        bus_start();
        send_byte(8'h27, a);
        send_byte(8'h24, a);
        check("R3 ignored until START", 32'(a), 32'd0);
        bus_start();
        send_byte(8'h24, a);
        check("R3 START re-enables", 32'(a), 32'd1);
        bus_stop();
        check_regs("R3 nothing stored");

        // R9: reset clears everything written.
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        wait_q();
        check_regs("R9 regs cleared");
        check("R9 oe cleared", 32'(sda_oe), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule